// File: doc/BRIEF.md
# Packed 64-bit SIMD Integer ALU

This block performs one packed integer operation per accepted beat on two 64-bit operands, `fs` and `ft`, and returns a 64-bit result `fd` one cycle later. The operand word is split into equal lanes of 8, 16, 32 or 64 bits. Every lane is computed on its own, and no carry, borrow or shift bit passes from one lane into the next. The available functions are wrapping add and subtract, signed and unsigned saturating add and subtract, unsigned rounding average, signed and unsigned maximum and minimum, mask-producing equality and signed greater-than compares, logical and arithmetic shifts, and an AND-NOT bitwise operation.

Operands and the opcode enter on a valid/ready stream. The result leaves on a second valid/ready stream through a single output register. An input beat is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged, `in_ready` stays low, and upstream has to wait. A source may raise `in_valid` without waiting for `in_ready`. A sink may take the result on any cycle in which `out_valid` is high.

The opcode is a 7-bit field. The low two bits select the lane width and the upper five bits select the function. Every function is defined for every lane width.

Top module: `simd_alu64`

## Requirements
- R1: A beat accepted at a clock edge (`in_valid` and `in_ready` both high) presents its result on `fd` with `out_valid` high from that edge onward. If no beat is accepted while the register is empty or being drained, `out_valid` is low after the edge.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and at the next edge `out_valid` stays high and `fd` keeps its value.
- R3: After reset, `out_valid` is low and `in_ready` is high.
- R4: `op[1:0]` sets the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. `op[6:2]` sets the function. Function 0 is a wrapping add and function 1 is a wrapping subtract (fs minus ft). No carry or borrow crosses a lane boundary.
- R5: Functions 2 and 4 are signed saturating add and subtract. Each lane result is clamped to the signed range of the lane. Functions 3 and 5 are the unsigned forms: an overflowing add gives all ones and an underflowing subtract gives zero.
- R6: Function 6 gives the unsigned rounding average of each lane, computed as (fs + ft + 1) / 2 with the intermediate sum one bit wider than the lane.
- R7: Functions 7 and 8 give the signed maximum and minimum of each lane. Functions 9 and 10 give the unsigned maximum and minimum.
- R8: Function 11 sets a lane to all ones when its fs and ft lanes are equal. Function 12 does the same when the fs lane is greater than the ft lane as signed numbers. A lane that fails the test becomes all zeros.
- R9: Functions 13, 14 and 15 shift each fs lane left logically, right logically, and right arithmetically. The count is `ft[6:0]` and is the same for all lanes. A count at or above the lane width gives zero for the logical shifts and a lane filled with its sign bit for the arithmetic shift.
- R10: Function 16 gives the bitwise AND of the inverse of fs with ft, at any lane width.
- R11: Function codes 17 to 31 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| op | input | 7 | Function code in bits 6:2, lane width in bits 1:0 |
| fs | input | DATA_W | First operand |
| ft | input | DATA_W | Second operand; its low bits also give the shift count |
| out_valid | output | 1 | Result present on fd |
| out_ready | input | 1 | Sink takes the result |
| fd | output | DATA_W | Packed result |

## Verification
The bench builds the block with its default `DATA_W` of 64. This gives a 7-bit shift count, so every count from 0 to 127 can be reached. Counts just below, at and above each of the four lane widths are exercised, and both the saturating clamp points and the lane sign bits sit at their natural positions. All 128 opcode values, the reserved function codes included, are swept against lane-boundary operands (zero, all ones, signed maximum, signed minimum, one). A random phase then toggles `out_ready` so that the hold and stall behaviour is driven under real back-pressure.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int OP_W     = 7;
  localparam int FUNC_W   = 5;
  localparam int SIZE_W   = 2;
  localparam int NUM_SIZE = 1 << SIZE_W;
  localparam int MIN_LANE = 8;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD   = 5'd0,
    FN_SUB   = 5'd1,
    FN_ADDSS = 5'd2,
    FN_ADDUS = 5'd3,
    FN_SUBSS = 5'd4,
    FN_SUBUS = 5'd5,
    FN_AVGU  = 5'd6,
    FN_MAXS  = 5'd7,
    FN_MINS  = 5'd8,
    FN_MAXU  = 5'd9,
    FN_MINU  = 5'd10,
    FN_CMPEQ = 5'd11,
    FN_CMPGT = 5'd12,
    FN_SLL   = 5'd13,
    FN_SRL   = 5'd14,
    FN_SRA   = 5'd15,
    FN_ANDN  = 5'd16
  } func_e;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic [SIZE_W-1:0] size;
  } op_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W    = 8,
  parameter int SH_W = 7
) (
  input  func_e           func,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    y
);

  localparam logic [W-1:0]    ONES  = {W{1'b1}};
  localparam logic [W-1:0]    SMAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]    SMIN  = {1'b1, {(W-1){1'b0}}};
  localparam logic [SH_W-1:0] LIMIT = SH_W'(W);

  logic [W:0] usum, udif, ssum, sdif, avg_sum;
  logic       s_gt, s_lt, u_gt, u_lt, eq, sh_over;

  always_comb begin
    usum    = {1'b0, a} + {1'b0, b};
    udif    = {1'b0, a} - {1'b0, b};
    ssum    = {a[W-1], a} + {b[W-1], b};
    sdif    = {a[W-1], a} - {b[W-1], b};
    avg_sum = usum + (W+1)'(1);
    s_gt    = $signed(a) > $signed(b);
    s_lt    = $signed(a) < $signed(b);
    u_gt    = a > b;
    u_lt    = a < b;
    eq      = a == b;
    sh_over = shamt >= LIMIT;
  end

  always_comb begin
    case (func)
      FN_ADD:   y = usum[W-1:0];
      FN_SUB:   y = udif[W-1:0];
      FN_ADDSS: y = (ssum[W] != ssum[W-1]) ? (ssum[W] ? SMIN : SMAX) : ssum[W-1:0];
      FN_SUBSS: y = (sdif[W] != sdif[W-1]) ? (sdif[W] ? SMIN : SMAX) : sdif[W-1:0];
      FN_ADDUS: y = usum[W] ? ONES : usum[W-1:0];
      FN_SUBUS: y = udif[W] ? '0 : udif[W-1:0];
      FN_AVGU:  y = avg_sum[W:1];
      FN_MAXS:  y = s_gt ? a : b;
      FN_MINS:  y = s_lt ? a : b;
      FN_MAXU:  y = u_gt ? a : b;
      FN_MINU:  y = u_lt ? a : b;
      FN_CMPEQ: y = eq ? ONES : '0;
      FN_CMPGT: y = s_gt ? ONES : '0;
      FN_SLL:   y = sh_over ? '0 : (a << shamt);
      FN_SRL:   y = sh_over ? '0 : (a >> shamt);
      FN_SRA:   y = sh_over ? {W{a[W-1]}} : W'($signed(a) >>> shamt);
      FN_ANDN:  y = ~a & b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SH_W   = 7
) (
  input  func_e             func,
  input  logic [DATA_W-1:0] fs,
  input  logic [DATA_W-1:0] ft,
  output logic [DATA_W-1:0] y
);

  localparam int N_LANE = DATA_W / LANE_W;

  logic [SH_W-1:0] shamt;
  assign shamt = ft[SH_W-1:0];

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    simd_lane #(.W(LANE_W), .SH_W(SH_W)) lane_i (
      .func  (func),
      .a     (fs[g*LANE_W +: LANE_W]),
      .b     (ft[g*LANE_W +: LANE_W]),
      .shamt (shamt),
      .y     (y[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/simd_alu64.sv
module simd_alu64
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] fs,
  input  logic [DATA_W-1:0] ft,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] fd
);

  localparam int SH_W = $clog2(DATA_W) + 1;

  op_t   op_s;
  func_e fn;
  logic [DATA_W-1:0] grp_y [NUM_SIZE];
  logic [DATA_W-1:0] result;
  logic              take;

  assign op_s = op_t'(op);
  assign fn   = func_e'(op_s.func);

  for (genvar s = 0; s < NUM_SIZE; s++) begin : g_size
    simd_lane_group #(
      .DATA_W (DATA_W),
      .LANE_W (MIN_LANE << s),
      .SH_W   (SH_W)
    ) grp_i (
      .func (fn),
      .fs   (fs),
      .ft   (ft),
      .y    (grp_y[s])
    );
  end

  assign result   = grp_y[op_s.size];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd <= '0;
    end else if (take) begin
      fd <= result;
    end
  end

endmodule

// File: rtl/simd_alu64_chk.sv
module simd_alu64_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [6:0]        op,
  input logic [DATA_W-1:0] fs,
  input logic [DATA_W-1:0] ft,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] fd
);

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(fd));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  andn_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op[6:2] == 5'd16 |=> fd == (~$past(fs) & $past(ft)));

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op[6:2] > 5'd16 |=> fd == '0);

endmodule

bind simd_alu64 simd_alu64_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .fs        (fs),
  .ft        (ft),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .fd        (fd)
);

// File: tb/simd_alu64_tb_top.sv
module simd_alu64_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  op_i = '0;
  logic [63:0] fs_i = '0;
  logic [63:0] ft_i = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] fd;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [6:0]  op;
    logic [63:0] exp;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;

  simd_alu64 dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op_i),
    .fs        (fs_i),
    .ft        (ft_i),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .fd        (fd)
  );

  function automatic string req_of(input logic [6:0] o);
    int f = int'(o[6:2]);
    if (f <= 1)  return "R4";
    if (f <= 5)  return "R5";
    if (f == 6)  return "R6";
    if (f <= 10) return "R7";
    if (f <= 12) return "R8";
    if (f <= 15) return "R9";
    if (f == 16) return "R10";
    return "R11";
  endfunction

  function automatic logic [63:0] ref_op(input logic [6:0] o, input logic [63:0] x,
                                         input logic [63:0] y);
    int w, n, sh;
    logic [63:0] res;
    logic signed [66:0] ua, ub, sa, sb, umax, smax, smin, r, t;
    w = 8 << o[1:0];
    n = 64 / w;
    sh = int'(y[6:0]);
    res = '0;
    umax = (67'sd1 <<< w) - 67'sd1;
    smax = (67'sd1 <<< (w - 1)) - 67'sd1;
    smin = -(67'sd1 <<< (w - 1));
    for (int l = 0; l < n; l++) begin
      ua = $signed({3'b000, (x >> (l * w))}) & umax;
      ub = $signed({3'b000, (y >> (l * w))}) & umax;
      sa = ua[w-1] ? ua - (umax + 67'sd1) : ua;
      sb = ub[w-1] ? ub - (umax + 67'sd1) : ub;
      case (int'(o[6:2]))
        0:  r = ua + ub;
        1:  r = ua - ub;
        2:  begin t = sa + sb; r = (t > smax) ? smax : (t < smin) ? smin : t; end
        4:  begin t = sa - sb; r = (t > smax) ? smax : (t < smin) ? smin : t; end
        3:  begin t = ua + ub; r = (t > umax) ? umax : t; end
        5:  r = (ua < ub) ? 67'sd0 : ua - ub;
        6:  r = (ua + ub + 67'sd1) >>> 1;
        7:  r = (sa > sb) ? ua : ub;
        8:  r = (sa < sb) ? ua : ub;
        9:  r = (ua > ub) ? ua : ub;
        10: r = (ua < ub) ? ua : ub;
        11: r = (ua == ub) ? umax : 67'sd0;
        12: r = (sa > sb) ? umax : 67'sd0;
        13: r = (sh >= w) ? 67'sd0 : (ua <<< sh);
        14: r = (sh >= w) ? 67'sd0 : (ua >>> sh);
        15: r = (sh >= w) ? ((sa < 0) ? umax : 67'sd0) : (sa >>> sh);
        16: r = ~ua & ub;
        default: r = 67'sd0;
      endcase
      res = res | (64'(r & umax) << (l * w));
    end
    return res;
  endfunction

  task automatic send(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    item_t it;
    op_i = o;
    fs_i = a;
    ft_i = b;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    it.op = o;
    it.exp = ref_op(o, a, b);
    sb_q.push_back(it);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // back-pressure driver
  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  // scoreboard monitor, plus hold check under stall
  logic        prev_stall = 1'b0;
  logic [63:0] prev_fd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || fd !== prev_fd) begin
          errors++;
          $display("FAIL R2 hold: out_valid=%0b fd=%h expected out_valid=1 fd=%h",
                   out_valid, fd, prev_fd);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R2 in_ready=%0b expected 0 during stall", in_ready);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_fd = fd;
      if (out_valid && out_ready) begin
        item_t it;
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result fd=%h expected no output", fd);
        end else begin
          it = sb_q.pop_front();
          if (fd !== it.exp) begin
            errors++;
            $display("FAIL %s op=%h actual=%h expected=%h", req_of(it.op), it.op, fd, it.exp);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  logic [63:0] pats [12] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080,
    64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000,
    64'h7FFF_FFFF_7FFF_FFFF, 64'h8000_0000_8000_0000,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'h0101_0101_0101_0101, 64'h807F_01FF_FF7F_8000
  };

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R3
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R3 out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk);
    #1;
    // R1 latency and drain
    send(7'h00, 64'h00FF_0001_7FFF_FFFF, 64'h0001_0001_0001_0001);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R1 out_valid=%0b expected 1 after accept", out_valid);
    end
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_valid=%0b expected 0 after drain", out_valid);
    end
    // all opcodes, boundary operand pairs (R4..R11)
    for (int o = 0; o < 128; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          send(7'(o), pats[i], pats[j]);
    // R9 shift-count sweep around each lane width
    for (int f = 13; f <= 15; f++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c <= 70; c++) begin
          send({5'(f), 2'(s)}, 64'h8123_4567_F9AB_CDEF, 64'(c));
          send({5'(f), 2'(s)}, 64'h7EDC_BA98_0654_3210, 64'(c) | 64'hFFFF_FF00);
        end
    // random phase with back-pressure (R2, R4 lane isolation)
    stall_mode = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] ro;
      ro = {5'($urandom_range(0, 17)), 2'($urandom_range(0, 3))};
      send(ro, {$urandom, $urandom}, {$urandom, $urandom});
    end
    stall_mode = 1'b0;
    while (sb_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule